// File: doc/BRIEF.md
# Recirculating Longest-Prefix-Match Lookup Engine

This block resolves 32-bit IPv4 destination addresses to a forwarding result by longest prefix match against a three-level trie. All levels share one pipelined synchronous table memory with a fixed read latency, and that memory sits outside the block. A lookup reads the top-level region first, using the upper 16 address bits as a direct index. If the word it gets back is a branch, the lookup goes round again to the memory, indexing a 256-word block with the next address byte. This repeats until a leaf word is returned, so each lookup needs one, two or three reads. The trie is built so that the third read always returns a leaf.

Addresses arrive on a ready/valid input together with a caller-chosen tag. Results leave on a ready/valid output that carries the same tag. A lookup that needs one read can overtake a lookup that needs three, so results may leave in a different order from the one in which they arrived. The tag is what matches each result to its request. Inside the block, a side queue holds the unused low address bits and the tag of every request whose memory read is in flight. A response queue holds the returned table words until they are consumed.

Each cycle the controller looks at the oldest response and puts it in one of three states:
- HEAD_NONE: no response is waiting.
- HEAD_LEAF: a result is ready to leave.
- HEAD_BRANCH: the lookup must recirculate.

The memory port then has one of three owners:
- PORT_IDLE: no read is issued.
- PORT_RECIRC: the read belongs to a recirculating lookup.
- PORT_ENTER: the read belongs to a newly admitted lookup.

The allowed transitions are:
- A branch head always takes the port (HEAD_BRANCH → PORT_RECIRC).
- A leaf head leaves without using the port, so the port is free to admit a new lookup in the same cycle (HEAD_LEAF → PORT_ENTER).
- An empty head lets the port admit a new lookup if one is offered (HEAD_NONE → PORT_ENTER or PORT_IDLE).

Top module: `lpm_circ_engine`

## Requirements
- R1: After reset, out_valid and mem_req_valid are 0 and in_ready is 1.
- R2: In the cycle a lookup is accepted (in_valid and in_ready both 1), the block issues a memory read (mem_req_valid=1) at address in_addr[31:16], zero-extended to the memory address width.
- R3: A table word with bit 31 = 0 is a branch, and its bits [MEM_AW-1:0] hold a block base pointer. The second read of a lookup goes to that pointer + in_addr[15:8]. The third read goes to the pointer returned by the second read + in_addr[7:0].
- R4: A table word with bit 31 = 1 is a leaf. The lookup that reads it ends there, whether that is its first, second or third read, and its result is bits [30:0] of that word.
- R5: While the oldest response is a branch, in_ready is 0 and the memory port carries the recirculating read. Recirculation therefore has priority over new entries.
- R6: A result may leave (out_valid and out_ready both 1) in the same cycle that a new lookup is accepted.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_result and out_tag keep their values in the next cycle.
- R8: At most DEPTH lookups are in flight at once. Once DEPTH have been accepted and none has left, in_ready stays 0.
- R9: Every accepted lookup produces exactly one result, and that result carries the tag given at acceptance. Results may leave out of order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lookup request offered |
| in_ready | output | 1 | Block can accept a lookup this cycle |
| in_addr | input | 32 | Destination address to resolve |
| in_tag | input | TAG_W | Caller tag returned with the result |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 31 | Leaf value of the matching prefix |
| out_tag | output | TAG_W | Tag of the finished lookup |
| mem_req_valid | output | 1 | Table read issued this cycle |
| mem_req_addr | output | MEM_AW | Table word address |
| mem_rsp_valid | input | 1 | Table word returned, fixed latency after its read |
| mem_rsp_data | input | 32 | Returned table word |

## Verification
The bench uses a trie in which every leaf value encodes the index it sits at. Two faults would therefore show up directly as wrong results: adding the wrong address byte to the pointer, and forgetting to shift the saved bits before the next level. A long run of three-level lookups keeps the port busy recirculating. During that run, a design that let a new entry win the port would be seen accepting input while a recirculating read goes out. A phase with the output held back fills the engine. It exposes two faults: a design that admits more than DEPTH lookups and overflows its queues, and a design whose result changes while stalled. Mixed one- and three-level traffic with a ready output must show acceptance and exit in the same cycle. Throughout, every tag must come back exactly once, or the scoreboard is left with missing or extra entries.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int WORD_W   = 32;
    localparam int LEAF_BIT = 31;
    localparam int VAL_W    = 31;
    localparam int KEY_W    = 16;   // bits still to be consumed after entry
    localparam int STEP_W   = 8;    // bits consumed per lower level

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        HEAD_NONE,
        HEAD_LEAF,
        HEAD_BRANCH
    } head_kind_e;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_RECIRC,
        PORT_ENTER
    } port_owner_e;

    function automatic logic word_is_leaf(input word_t w);
        return w[LEAF_BIT];
    endfunction

endpackage

// File: rtl/lpm_fifo.sv
module lpm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     store [DEPTH];
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [CNT_W-1:0] count;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign dout  = store[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (push) wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
            if (pop)  rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wr_idx] <= din;
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/lpm_port_ctrl.sv
module lpm_port_ctrl
    import lpm_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int MEM_AW = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    // oldest returned table word
    input  logic                      rsp_vld,
    input  word_t                     rsp_word,
    output logic                      rsp_pop,
    // oldest in-flight context
    input  logic [TAG_W+KEY_W-1:0]    ctx_head,
    input  logic                      ctx_full,
    output logic                      ctx_pop,
    output logic                      ctx_push,
    output logic [TAG_W+KEY_W-1:0]    ctx_din,
    // request side
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [31:0]               in_addr,
    input  logic [TAG_W-1:0]          in_tag,
    // result side
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [VAL_W-1:0]          out_result,
    output logic [TAG_W-1:0]          out_tag,
    // memory port
    output logic                      mem_req_valid,
    output logic [MEM_AW-1:0]         mem_req_addr
);
    head_kind_e  head_kind;
    port_owner_e port_owner;

    logic [TAG_W-1:0]  head_tag;
    logic [KEY_W-1:0]  head_bits;
    logic [STEP_W-1:0] head_step;
    logic [MEM_AW-1:0] next_ptr;

    assign head_tag  = ctx_head[TAG_W+KEY_W-1:KEY_W];
    assign head_bits = ctx_head[KEY_W-1:0];
    assign head_step = head_bits[KEY_W-1:KEY_W-STEP_W];
    assign next_ptr  = rsp_word[MEM_AW-1:0] + {{(MEM_AW-STEP_W){1'b0}}, head_step};

    // classify the oldest response
    always_comb begin
        if (!rsp_vld)                   head_kind = HEAD_NONE;
        else if (word_is_leaf(rsp_word)) head_kind = HEAD_LEAF;
        else                            head_kind = HEAD_BRANCH;
    end

    // consume the head, arbitrate the memory port
    always_comb begin
        rsp_pop    = 1'b0;
        ctx_pop    = 1'b0;
        out_valid  = 1'b0;
        port_owner = PORT_IDLE;
        unique case (head_kind)
            HEAD_BRANCH: begin
                port_owner = PORT_RECIRC;
                rsp_pop    = 1'b1;
                ctx_pop    = 1'b1;
            end
            HEAD_LEAF: begin
                out_valid = 1'b1;
                rsp_pop   = out_ready;
                ctx_pop   = out_ready;
            end
            HEAD_NONE: begin
            end
            default: begin
            end
        endcase
        in_ready = (port_owner != PORT_RECIRC) && (!ctx_full || ctx_pop);
        if (in_valid && in_ready) port_owner = PORT_ENTER;
    end

    // drive the memory port and the context queue
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        ctx_push      = 1'b0;
        ctx_din       = '0;
        unique case (port_owner)
            PORT_RECIRC: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = next_ptr;
                ctx_push      = 1'b1;
                ctx_din       = {head_tag, head_bits[KEY_W-STEP_W-1:0], {STEP_W{1'b0}}};
            end
            PORT_ENTER: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {{(MEM_AW-KEY_W){1'b0}}, in_addr[31:KEY_W]};
                ctx_push      = 1'b1;
                ctx_din       = {in_tag, in_addr[KEY_W-1:0]};
            end
            PORT_IDLE: begin
            end
            default: begin
            end
        endcase
    end

    assign out_result = rsp_word[VAL_W-1:0];
    assign out_tag    = head_tag;

    // R5
    recirc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_word[LEAF_BIT]) |-> (!in_ready && mem_req_valid));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_tag)));

endmodule

// File: rtl/lpm_circ_engine.sv
module lpm_circ_engine
    import lpm_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int MEM_AW = 24,
    parameter int DEPTH  = 8    // keep at least the memory latency
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_addr,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [30:0]       out_result,
    output logic [TAG_W-1:0]  out_tag,
    output logic              mem_req_valid,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);
    localparam int CTX_W = TAG_W + KEY_W;

    logic             ctx_push, ctx_pop, ctx_full, ctx_empty;
    logic [CTX_W-1:0] ctx_din, ctx_head;
    logic             rsp_pop, rsp_full, rsp_empty;
    word_t            rsp_word;

    lpm_fifo #(.W(CTX_W), .DEPTH(DEPTH)) u_ctx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ctx_push),
        .din   (ctx_din),
        .pop   (ctx_pop),
        .dout  (ctx_head),
        .full  (ctx_full),
        .empty (ctx_empty)
    );

    lpm_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rsp_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (mem_rsp_valid),
        .din   (mem_rsp_data),
        .pop   (rsp_pop),
        .dout  (rsp_word),
        .full  (rsp_full),
        .empty (rsp_empty)
    );

    lpm_port_ctrl #(.TAG_W(TAG_W), .MEM_AW(MEM_AW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .rsp_vld       (!rsp_empty),
        .rsp_word      (rsp_word),
        .rsp_pop       (rsp_pop),
        .ctx_head      (ctx_head),
        .ctx_full      (ctx_full),
        .ctx_pop       (ctx_pop),
        .ctx_push      (ctx_push),
        .ctx_din       (ctx_din),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_addr       (in_addr),
        .in_tag        (in_tag),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_result    (out_result),
        .out_tag       (out_tag),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr)
    );

    // R2
    enter_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (mem_req_valid && mem_req_addr[KEY_W-1:0] == in_addr[31:KEY_W]));

    // R9
    rsp_has_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_empty |-> !ctx_empty);

    // R8
    rsp_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (!rsp_full || rsp_pop));

endmodule

// File: tb/tb_lpm_circ_engine.sv
`timescale 1ns/1ps
module tb_lpm_circ_engine;
    localparam int TAG_W  = 8;
    localparam int MEM_AW = 24;
    localparam int DEPTH  = 8;
    localparam int LAT    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_addr = '0;
    logic [TAG_W-1:0]  in_tag = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [30:0]       out_result;
    logic [TAG_W-1:0]  out_tag;
    logic              mem_req_valid;
    logic [MEM_AW-1:0] mem_req_addr;
    logic              mem_rsp_valid;
    logic [31:0]       mem_rsp_data;

    always #2.5 clk = ~clk;

    lpm_circ_engine #(.TAG_W(TAG_W), .MEM_AW(MEM_AW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result), .out_tag(out_tag),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // table memory model
    logic [31:0] tbl [int];
    logic              pv [LAT];
    logic [MEM_AW-1:0] pa [LAT];

    function automatic logic [31:0] mem_rd(input int a);
        if (tbl.exists(a)) return tbl[a];
        return 32'h8000_DEAD;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) pv[i] <= 1'b0;
        end else begin
            pv[0] <= mem_req_valid;
            pa[0] <= mem_req_addr;
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1];
                pa[i] <= pa[i-1];
            end
        end
    end
    assign mem_rsp_valid = pv[LAT-1];
    assign mem_rsp_data  = mem_rd(int'(pa[LAT-1]));

    // software reference of the three-level walk
    function automatic logic [30:0] model(input logic [31:0] a);
        logic [31:0] w;
        w = mem_rd(int'(a[31:16]));
        if (w[31]) return w[30:0];
        w = mem_rd(int'(w[23:0]) + int'(a[15:8]));
        if (w[31]) return w[30:0];
        w = mem_rd(int'(w[23:0]) + int'(a[7:0]));
        return w[30:0];
    endfunction

    int errors = 0;
    int checks = 0;
    int accepted = 0;
    int overlap = 0;
    logic [TAG_W-1:0] next_tag = '0;
    logic [30:0] sb [int];
    logic        prev_stall = 1'b0;
    logic [30:0] prev_res;
    logic [TAG_W-1:0] prev_tag;
    bit          mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: record accepted lookups, score results
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_stall) begin
                // R7
                check(out_valid && out_result == prev_res && out_tag == prev_tag, "R7",
                      "stalled result changed", {1'b0, out_result}, {1'b0, prev_res});
            end
            prev_stall = out_valid && !out_ready;
            prev_res   = out_result;
            prev_tag   = out_tag;
            if (in_valid && in_ready) begin
                // R2
                check(mem_req_valid && mem_req_addr == {8'h0, in_addr[31:16]}, "R2",
                      "entry read address", {8'h0, mem_req_addr}, {16'h0, in_addr[31:16]});
                sb[int'(in_tag)] = model(in_addr);
                accepted++;
            end else if (mem_req_valid) begin
                // R5: a read without an entry is a recirculation and blocks input
                check(!in_ready, "R5", "in_ready during recirculation", {31'h0, in_ready}, 32'h0);
            end
            if (out_valid && out_ready) begin
                if (in_valid && in_ready) overlap++;
                // R9
                check(sb.exists(int'(out_tag)), "R9", "unknown tag", {24'h0, out_tag}, 32'h0);
                if (sb.exists(int'(out_tag))) begin
                    // R3 R4
                    check(out_result == sb[int'(out_tag)], "R4", "result value",
                          {1'b0, out_result}, {1'b0, sb[int'(out_tag)]});
                    sb.delete(int'(out_tag));
                end
            end
        end
    end

    task automatic send(input logic [31:0] a);
        bit acc;
        in_valid = 1'b1;
        in_addr  = a;
        in_tag   = next_tag;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        in_valid = 1'b0;
        next_tag = next_tag + 1'b1;
    endtask

    function automatic logic [31:0] gen(input int kind);
        logic [7:0]  b1 = 8'($urandom);
        logic [7:0]  b2 = 8'($urandom);
        unique case (kind)
            0: return {16'h0A12, 8'hC8, b2};     // three levels
            1: return {16'h0A12, b1, b2};        // mostly two levels
            2: return {16'h0705, b1, b2};        // one level
            3: return {16'h070E, b1, b2};        // two levels
            4: return {16'h0C00, b1, b2};        // three levels
            default: return {8'h33, b1, b2, b1}; // default leaf
        endcase
    endfunction

    task automatic drain();
        for (int i = 0; i < 500 && sb.size() != 0; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // table contents: leaf values encode their own index
        tbl[32'h0A12] = 32'h0001_0000;
        tbl[32'h0705] = 32'h8000_0055;
        tbl[32'h070E] = 32'h0001_0200;
        tbl[32'h0C00] = 32'h0001_0300;
        for (int b = 0; b < 256; b++) begin
            tbl[32'h10000 + b] = (b == 8'hC8) ? 32'h0001_0100 : 32'h8001_1000 + b;
            tbl[32'h10100 + b] = 32'h8003_0000 + b;
            tbl[32'h10200 + b] = 32'h8004_0000 + b;
            tbl[32'h10300 + b] = 32'h0001_0400;
            tbl[32'h10400 + b] = 32'h8005_0000 + b;
        end

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!out_valid, "R1", "out_valid after reset", {31'h0, out_valid}, 32'h0);
        check(!mem_req_valid, "R1", "mem_req_valid after reset", {31'h0, mem_req_valid}, 32'h0);
        check(in_ready, "R1", "in_ready after reset", {31'h0, in_ready}, 32'h1);
        mon_on = 1'b1;
        @(posedge clk);
        #1;

        // mixed traffic
        for (int i = 0; i < 200; i++) send(gen(i % 6));
        drain();

        // R5: back-to-back three-level lookups keep the port recirculating
        for (int i = 0; i < 60; i++) send(gen((i % 2 == 0) ? 0 : 4));
        drain();

        // R8 R7: stall the output and try to overfill
        begin
            int base;
            out_ready = 1'b0;
            base = accepted;
            fork
                for (int i = 0; i < 20; i++) send(gen(2));
            join_none
            repeat (40) @(posedge clk);
            #1;
            // R8
            check(accepted - base == DEPTH, "R8", "lookups in flight while stalled",
                  accepted - base, DEPTH);
            check(!in_ready, "R8", "in_ready with engine full", {31'h0, in_ready}, 32'h0);
            out_ready = 1'b1;
            wait fork;
            drain();
        end

        // random output pressure, mixed depth
        fork
            for (int i = 0; i < 150; i++) send(gen(i % 5));
            for (int i = 0; i < 900; i++) begin
                @(posedge clk);
                #1;
                out_ready = ($urandom % 3) != 0;
            end
        join_any
        out_ready = 1'b1;
        disable fork;
        in_valid = 1'b0;
        drain();

        // R9
        check(sb.size() == 0, "R9", "lookups without result", sb.size(), 0);
        // R6
        check(overlap > 0, "R6", "cycles with entry and exit together", overlap, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule